// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block is the interrupt core of a sixteen-register parallel-I/O peripheral on an 8-bit processor bus. It keeps seven sticky interrupt flags, one per source, and seven enable bits. It drives a single level-sensitive interrupt request that is high while any enabled flag is pending. Timer and shift-register logic elsewhere in the peripheral raise flags through one-cycle set pulses. They can also drop flags through clear pulses when their own registers are accessed.

The block also owns the peripheral mode register. For each of the two ports, a three-bit field of that register chooses whether an access to that port's data register clears both of the port's two flags or only one of them. The processor reads the flag register with a live summary in its top bit. It clears flags by writing ones to the flag register. It changes enables with a write whose top bit chooses between setting and clearing the marked bits.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A read at offset 0xD returns the seven flags in bits 6:0, and bit 7 is 1 exactly when (flags AND enables) is nonzero.
- R2: `irq_out` is registered. It is high in the cycle after a clock edge at which (flags AND enables) was nonzero, and low otherwise.
- R3: A write at offset 0xD clears each flag whose data bit (6:0) is 1. Flags written as 0 keep their value.
- R4: A write at offset 0xE with data bit 7 = 1 sets the enable bits marked by ones in data bits 6:0. With data bit 7 = 0 it clears those enable bits. Unmarked enables keep their value.
- R5: A read at offset 0xE returns the enables in bits 6:0, and bit 7 always reads 1.
- R6: A read or write at offset 0x1 or 0xF clears flags 0 and 1. When mode bits 3:1 are 001 or 011, only flag 1 is cleared.
- R7: A read or write at offset 0x0 clears flags 3 and 4. When mode bits 7:5 are 001 or 011, only flag 4 is cleared.
- R8: While `rst_n` is low at a clock edge, flags, enables and mode register go to zero and `irq_out` goes low.
- R9: A set pulse on a flag wins over any clear of that flag in the same cycle.
- R10: A one-cycle pulse on `src_set[i]` sets flag i, and the flag stays set until a clear reaches it.
- R11: A write at offset 0xC stores all eight data bits in the mode register, and a read at 0xC returns them. Offsets this block does not own read as 0x00.
- R12: A pulse on `src_clr[i]` clears flag i, unless a set reaches it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational from state |
| src_set | input | 7 | Set pulses from the timer and shift-register logic |
| src_clr | input | 7 | Clear pulses from accesses to other registers of the peripheral |
| irq_out | output | 1 | Level interrupt request, active high |

## Verification
Register contents change at the clock edge that ends the access or pulse cycle. Read data is combinational, so it shows the new state in the cycle after that edge. `irq_out` trails the flag and enable state by one further edge. The bench drives each operation just after a falling edge and samples read data and `irq_out` one nanosecond later, before the next rising edge. Its reference model then updates at that rising edge: the expected `irq_out` takes the summary of the pre-edge model state, and the expected registers take their post-edge values. This keeps every comparison on the cycle where the value is due.

// File: rtl/irqc_pkg.sv
// Package: shared widths, register offsets and mode decode for the
// interrupt flag/enable controller. Assumes an 8-bit data bus with the
// top data bit reserved for summary / set-clear selection.
package irqc_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_SRC = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_PORTB     = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_PORTA     = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_MODE      = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_FLAGS     = 4'hD;
    localparam logic [ADDR_W-1:0] OFS_ENABLE    = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_PORTA_RAW = 4'hF;

    // True when a port mode field selects single-flag clearing on access.
    function automatic logic single_clear_mode(input logic [2:0] fld);
        return (fld == 3'b001) || (fld == 3'b011);
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
// Flag bank: one sticky bit per interrupt source. Set pulses take
// priority over any clear arriving in the same cycle. Assumes set and
// clear inputs are already qualified single-cycle pulses.
module irqc_flag_bank #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;

        // Hold one source flag: reset, set-first, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
        end

        assign flags_o[i] = bit_q;

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        // R12
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
        // R10
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
    end
endmodule

// File: rtl/irqc_enable_bank.sv
// Enable bank: per-source enable bits updated by a single write whose
// top data bit selects set (1) or clear (0) of the marked bits.
// Assumes wr_i is already decoded for the enable register offset.
module irqc_enable_bank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-2:0] en_o
);
    localparam int NSRC = DATA_W - 1;

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] mark;
    logic            set_sel;

    assign mark    = wdata_i[NSRC-1:0];
    assign set_sel = wdata_i[DATA_W-1];

    // Apply a set-or-clear write to the marked enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_i) begin
            if (set_sel) en_q <= en_q | mark;
            else         en_q <= en_q & ~mark;
        end
    end

    assign en_o = en_q;

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && set_sel) |=> ((en_o & $past(mark)) == $past(mark)));
    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !set_sel) |=> ((en_o & $past(mark)) == '0));
    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irqc_port_ctrl.sv
// Port mode register and port-access clear decode. An access (read or
// write) to a port data offset produces clear pulses for that port's
// two flags, or only the upper one when the port's mode field selects
// single-flag clearing. Assumes access_i is a one-cycle strobe.
module irqc_port_ctrl
    import irqc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          access_i,
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] mode_o,
    output logic [DW-2:0] clr_o
);
    localparam int NSRC   = DW - 1;
    localparam int NPORTS = 2;

    logic [DW-1:0]   mode_q;
    logic [NSRC-1:0] port_mask [NPORTS];

    // Store the mode register on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (mode_wr_i) mode_q <= wdata_i;
    end

    assign mode_o = mode_q;

    // Port 0 is port A (flags 0,1; field 3:1); port 1 is port B (flags 3,4; field 7:5).
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int LOW_BIT = (p == 0) ? 0 : 3;
        localparam int FLD_LSB = (p == 0) ? 1 : 5;

        logic hit;
        logic single;

        if (p == 0) begin : g_a
            assign hit = (addr_i == OFS_PORTA) || (addr_i == OFS_PORTA_RAW);
        end else begin : g_b
            assign hit = (addr_i == OFS_PORTB);
        end

        assign single = single_clear_mode(mode_q[FLD_LSB+2:FLD_LSB]);

        // Build this port's clear mask for the current access.
        always_comb begin
            port_mask[p] = '0;
            if (access_i && hit) begin
                port_mask[p][LOW_BIT+1] = 1'b1;
                port_mask[p][LOW_BIT]   = !single;
            end
        end
    end

    assign clr_o = port_mask[0] | port_mask[1];

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_i |=> $stable(mode_o));
    // R11
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> (mode_o == $past(wdata_i)));
endmodule

// File: rtl/irq_flag_ctrl.sv
// Top of the interrupt flag/enable controller. Decodes bus accesses,
// merges all clear sources, drives the read mux and registers the
// interrupt request. Assumes single-cycle read/write strobes and that
// registers at offsets it does not own are read by other blocks.
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int AW = irqc_pkg::ADDR_W,
    parameter int DW = irqc_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-2:0] src_set,
    input  logic [DW-2:0] src_clr,
    output logic          irq_out
);
    localparam int NSRC = DW - 1;

    logic            wr_flags;
    logic            wr_enable;
    logic            wr_mode;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] enables;
    logic [DW-1:0]   mode;
    logic [NSRC-1:0] port_clr;
    logic [NSRC-1:0] write_clr;
    logic [NSRC-1:0] all_clr;
    logic            pending;
    logic            irq_q;

    assign wr_flags  = bus_wr && (bus_addr == OFS_FLAGS);
    assign wr_enable = bus_wr && (bus_addr == OFS_ENABLE);
    assign wr_mode   = bus_wr && (bus_addr == OFS_MODE);
    assign write_clr = wr_flags ? bus_wdata[NSRC-1:0] : '0;
    assign all_clr   = write_clr | port_clr | src_clr;

    irqc_port_ctrl #(.AW(AW), .DW(DW)) i_port_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr_i (wr_mode),
        .wdata_i   (bus_wdata),
        .access_i  (bus_wr || bus_rd),
        .addr_i    (bus_addr),
        .mode_o    (mode),
        .clr_o     (port_clr)
    );

    irqc_flag_bank #(.NSRC(NSRC)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_set),
        .clr_i   (all_clr),
        .flags_o (flags)
    );

    irqc_enable_bank #(.DATA_W(DW)) i_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_enable),
        .wdata_i (bus_wdata),
        .en_o    (enables)
    );

    assign pending = |(flags & enables);

    // Register the interrupt request from the current pending summary.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending;
    end

    assign irq_out = irq_q;

    // Select read data for the offsets owned by this block.
    always_comb begin
        case (bus_addr)
            OFS_FLAGS:  bus_rdata = {pending, flags};
            OFS_ENABLE: bus_rdata = {1'b1, enables};
            OFS_MODE:   bus_rdata = mode;
            default:    bus_rdata = '0;
        endcase
    end

    // R2
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_out);
    // R2
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_out);
    // R3
    flag_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flags |=> ((flags & $past(bus_wdata[NSRC-1:0]) & ~$past(src_set)) == '0));
    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && enables == '0 && mode == '0 && !irq_out));
endmodule

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] src_set = '0;
    logic [6:0] src_clr = '0;
    logic       irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [6:0] m_flags = '0;
    logic [6:0] m_en    = '0;
    logic [7:0] m_mode  = '0;
    logic       m_irq   = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_set(src_set), .src_clr(src_clr), .irq_out(irq_out)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'hC:    return m_mode;
            4'hD:    return {|(m_flags & m_en), m_flags};
            4'hE:    return {1'b1, m_en};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic single_mode(input logic [2:0] f);
        return (f == 3'b001) || (f == 3'b011);
    endfunction

    function automatic logic [6:0] port_clear(input logic [3:0] a, input logic acc);
        logic [6:0] m = '0;
        if (acc && (a == 4'h1 || a == 4'hF)) begin
            m[1] = 1'b1;
            m[0] = !single_mode(m_mode[3:1]);
        end
        if (acc && a == 4'h0) begin
            m[4] = 1'b1;
            m[3] = !single_mode(m_mode[7:5]);
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus/pulse cycle: drive after the falling edge, check, then advance the model.
    task automatic step(input string req, input logic [3:0] a, input logic w, input logic r,
                        input logic [7:0] d, input logic [6:0] s, input logic [6:0] c);
        logic [6:0] clr;
        logic       nirq;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; src_set = s; src_clr = c;
        #1;
        if (r) check(req, bus_rdata, exp_read(a));
        check("R2", {7'b0, irq_out}, {7'b0, m_irq});
        @(posedge clk);
        nirq = |(m_flags & m_en);
        clr  = c | port_clear(a, w || r) | ((w && a == 4'hD) ? d[6:0] : 7'b0);
        m_flags = s | (m_flags & ~clr);
        if (w && a == 4'hE) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        if (w && a == 4'hC) m_mode = d;
        m_irq = nirq;
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        step(req, a, 1'b0, 1'b1, 8'h00, 7'h00, 7'h00);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step("WR", a, 1'b1, 1'b0, d, 7'h00, 7'h00);
    endtask

    task automatic pulse(input logic [6:0] s, input logic [6:0] c);
        step("PULSE", 4'h2, 1'b0, 1'b0, 8'h00, s, c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; src_set = '0; src_clr = '0;
        repeat (3) @(posedge clk);
        m_flags = '0; m_en = '0; m_mode = '0; m_irq = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Port-access clear case: fill flags, set mode, access, read back.
    task automatic port_case(input string req, input logic [7:0] mode_v, input logic [3:0] a,
                             input logic is_wr, input logic [7:0] exp_flags);
        wr(4'hC, mode_v);
        pulse(7'h7F, 7'h00);
        step(req, a, is_wr, !is_wr, 8'h55, 7'h00, 7'h00);
        rd(req, 4'hD);
        check(req, {1'b0, bus_rdata[6:0]}, exp_flags);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        do_reset();

        // R8: reset state
        rd("R8", 4'hD);
        check("R8", bus_rdata, 8'h00);
        rd("R5", 4'hE);
        check("R5", bus_rdata, 8'h80);
        rd("R8", 4'hC);
        check("R8", {7'b0, irq_out}, 8'h00);

        // R10: a pulse sets a sticky flag; R1 summary low with no enable
        pulse(7'h04, 7'h00);
        rd("R10", 4'hD);
        rd("R10", 4'hD);
        check("R1", bus_rdata, 8'h04);

        // R4 set + R1 summary + R2 delayed irq
        wr(4'hE, 8'h84);
        rd("R4", 4'hE);
        check("R4", bus_rdata, 8'h84);
        rd("R1", 4'hD);
        check("R1", bus_rdata, 8'h84);
        check("R2", {7'b0, irq_out}, 8'h01);

        // R4 clear, others kept
        wr(4'hE, 8'h81);
        wr(4'hE, 8'h04);
        rd("R4", 4'hE);
        check("R4", bus_rdata, 8'h81);
        rd("R1", 4'hD);
        check("R1", bus_rdata, 8'h04);

        // R3: write-one-to-clear
        pulse(7'h7F, 7'h00);
        wr(4'hD, 8'h05);
        rd("R3", 4'hD);
        check("R3", {1'b0, bus_rdata[6:0]}, 8'h7A);

        // R9: set beats flag-register clear and external clear
        step("R9", 4'hD, 1'b1, 1'b0, 8'h02, 7'h02, 7'h00);
        pulse(7'h08, 7'h08);
        rd("R9", 4'hD);
        check("R9", {1'b0, bus_rdata[6:0]}, 8'h7A);

        // R12: external clear pulses
        pulse(7'h00, 7'h60);
        rd("R12", 4'hD);
        check("R12", {1'b0, bus_rdata[6:0]}, 8'h1A);

        // R6: port A accesses
        port_case("R6", 8'h00, 4'h1, 1'b0, 8'h7C);
        port_case("R6", 8'h02, 4'hF, 1'b1, 8'h7D);
        port_case("R6", 8'h06, 4'h1, 1'b1, 8'h7D);
        port_case("R6", 8'h0A, 4'hF, 1'b0, 8'h7C);

        // R7: port B accesses
        port_case("R7", 8'h00, 4'h0, 1'b1, 8'h67);
        port_case("R7", 8'h20, 4'h0, 1'b0, 8'h6F);
        port_case("R7", 8'h60, 4'h0, 1'b1, 8'h6F);
        port_case("R7", 8'h40, 4'h0, 1'b0, 8'h67);

        // R11: mode readback and unowned offsets
        wr(4'hC, 8'hA5);
        rd("R11", 4'hC);
        check("R11", bus_rdata, 8'hA5);
        rd("R11", 4'h7);
        check("R11", bus_rdata, 8'h00);

        // R8: mid-run reset
        wr(4'hE, 8'hFF);
        pulse(7'h7F, 7'h00);
        pulse(7'h00, 7'h00);
        check("R2", {7'b0, irq_out}, 8'h01);
        do_reset();
        #1;
        check("R8", {7'b0, irq_out}, 8'h00);
        rd("R8", 4'hE);
        check("R8", bus_rdata, 8'h80);
        rd("R8", 4'hC);
        check("R8", bus_rdata, 8'h00);

        // Random mix checked against the model
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] a;
            logic [1:0] op;
            logic [7:0] d;
            logic [6:0] s;
            logic [6:0] c;
            a  = 4'($urandom_range(0, 15));
            op = 2'($urandom_range(0, 3));
            d  = 8'($urandom);
            s  = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
            c  = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
            if ($urandom_range(0, 1) == 1) a = 4'($urandom_range(12, 15));
            step("RND", a, op == 2'd1, op >= 2'd2, d, s, c);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule